// File: doc/BRIEF.md
# Chainable Serial-Load Display Channel Register

This block turns a serial bit stream into a bank of parallel on/off commands for display sink drivers. Bits enter one at a time into a shift chain whenever the shift strobe is high on a clock edge. The last stage of the chain is brought out as a serial output, so several blocks can be wired in series and loaded from one data line.

A storage bank sits behind the shift chain. While its capture input is high it tracks the chain on every edge. When the capture input is low it keeps the value it last held. Each channel output is driven from this storage. A blanking input turns every channel off without touching the stored pattern. Holding the capture input high bypasses the storage, and the blanking input then hides the data while it is being shifted.

All inputs are sampled on the rising edge of a single clock. Reset is synchronous and active high. Every output comes from a register.

Top module: `chain_led_driver`

## Requirements
- R1: On a rising edge with `shift_en` high, the value on `sdi` is taken into stage 0, and stage 0 drives channel 0.
- R2: On such an edge every stage k passes its value to stage k+1. When `shift_en` is low the chain does not change.
- R3: `sdo` carries the top stage (CH-1). When `sdo` of one block feeds `sdi` of a second block, 2*CH shifts place the first CH bits in the second block.
- R4: On an edge with `latch_en` high, the storage takes the value the chain holds after that same edge.
- R5: On an edge with `latch_en` low, the storage and the channel outputs keep their value, even while shifting goes on.
- R6: From the first edge at which `blank` is sampled high, every bit of `sink_on` is 0.
- R7: `blank` does not change the stored pattern. From the first edge at which `blank` is sampled low, each channel again shows its stored bit.
- R8: A stored 1 sets its `sink_on` bit to 1 (sink on). A stored 0 sets it to 0.
- R9: After CH shifts, the first bit shifted in drives channel CH-1 and the last bit shifted in drives channel 0.
- R10: An edge with `rst` high clears the chain, the storage, `sink_on` and `sdo` to 0.
- R11: With `latch_en` held high and `blank` high during shifting, every output stays off. When `blank` drops, the outputs show the chain contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All inputs are sampled on its rising edge. |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift strobe. The chain advances on each edge where it is high. |
| sdi | input | 1 | Serial data in |
| latch_en | input | 1 | Storage capture. High means the storage follows the chain. |
| blank | input | 1 | High turns every channel off |
| sdo | output | 1 | Serial data out (top stage), used for chaining |
| sink_on | output | CH | Per-channel sink command. 1 means on. |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before each rising edge. They also assume CH is at least 2, so that a stage below the top stage exists. The stimulus changes inputs only on the falling edge. The cascade in the bench is built from identical blocks that share one clock, so the serial link between them is a plain register-to-register path. The bench model applies reset, shift, capture and blanking in the same order as the block and then compares both output vectors and the downstream serial output.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int CH_DEFAULT = 16;
  localparam int CH_MIN     = 2;
endpackage

// File: rtl/dsr_shift_chain.sv
module dsr_shift_chain #(
  parameter int CH = dsr_pkg::CH_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          sdi,
  output logic [CH-1:0] stage_q,
  output logic [CH-1:0] stage_nx
);
  // The chain moves toward the top stage. Stage 0 takes the serial input.
  always_comb begin
    if (shift_en) stage_nx = {stage_q[CH-2:0], sdi};
    else          stage_nx = stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_nx;
  end
endmodule

// File: rtl/dsr_latch_bank.sv
module dsr_latch_bank #(
  parameter int CH = dsr_pkg::CH_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_en,
  input  logic [CH-1:0] stage_nx,
  output logic [CH-1:0] lat_q,
  output logic [CH-1:0] lat_nx
);
  // Transparent behaviour, made synchronous: while capture is open,
  // each cell takes the chain value of this same edge.
  for (genvar i = 0; i < CH; i++) begin : g_cell
    assign lat_nx[i] = latch_en ? stage_nx[i] : lat_q[i];
    always_ff @(posedge clk) begin
      if (rst) lat_q[i] <= 1'b0;
      else     lat_q[i] <= lat_nx[i];
    end
  end
endmodule

// File: rtl/dsr_output_gate.sv
module dsr_output_gate #(
  parameter int CH = dsr_pkg::CH_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blank,
  input  logic [CH-1:0] lat_nx,
  output logic [CH-1:0] sink_on
);
  // Registered per-channel drive. Blanking masks the drive only.
  for (genvar i = 0; i < CH; i++) begin : g_drv
    always_ff @(posedge clk) begin
      if (rst) sink_on[i] <= 1'b0;
      else     sink_on[i] <= lat_nx[i] & ~blank;
    end
  end
endmodule

// File: rtl/chain_led_driver.sv
module chain_led_driver #(
  parameter int CH = dsr_pkg::CH_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          sdi,
  input  logic          latch_en,
  input  logic          blank,
  output logic          sdo,
  output logic [CH-1:0] sink_on
);
  localparam int TOP = CH - 1;

  logic [CH-1:0] stage_q;
  logic [CH-1:0] stage_nx;
  logic [CH-1:0] lat_q;
  logic [CH-1:0] lat_nx;

  dsr_shift_chain #(.CH(CH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .sdi      (sdi),
    .stage_q  (stage_q),
    .stage_nx (stage_nx)
  );

  dsr_latch_bank #(.CH(CH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .latch_en (latch_en),
    .stage_nx (stage_nx),
    .lat_q    (lat_q),
    .lat_nx   (lat_nx)
  );

  dsr_output_gate #(.CH(CH)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .blank   (blank),
    .lat_nx  (lat_nx),
    .sink_on (sink_on)
  );

  assign sdo = stage_q[TOP];
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int CH = dsr_pkg::CH_DEFAULT
) (
  input logic          clk,
  input logic          rst,
  input logic          shift_en,
  input logic          sdi,
  input logic          latch_en,
  input logic          blank,
  input logic          sdo,
  input logic [CH-1:0] sink_on,
  input logic [CH-1:0] stage_q,
  input logic [CH-1:0] lat_q
);
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stage_q[0] == $past(sdi));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stage_q[CH-1:1] == $past(stage_q[CH-2:0]));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stage_q));

  p_serial_out_r3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sdo == $past(stage_q[CH-2]));

  p_follow_r4: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> lat_q == stage_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(lat_q));

  p_blank_off_r6: assert property (@(posedge clk) disable iff (rst)
    blank |=> sink_on == '0);

  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (blank && !latch_en) |=> $stable(lat_q));

  p_show_r8: assert property (@(posedge clk) disable iff (rst)
    !blank |=> sink_on == lat_q);

  p_clear_r10: assert property (@(posedge clk)
    rst |=> (sink_on == '0 && sdo == 1'b0 && lat_q == '0));
endmodule

bind chain_led_driver dsr_checker #(.CH(CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shift_en (shift_en),
  .sdi      (sdi),
  .latch_en (latch_en),
  .blank    (blank),
  .sdo      (sdo),
  .sink_on  (sink_on),
  .stage_q  (stage_q),
  .lat_q    (lat_q)
);

// File: tb/chain_led_driver_test.sv
`timescale 1ns/1ps
module chain_led_driver_test;
  localparam int W = 16;
  localparam int L = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0;
  logic sdi = 1'b0;
  logic latch_en = 1'b0;
  logic blank = 1'b0;
  logic sdo_a, sdo_b;
  logic [W-1:0] out_a, out_b;

  always #4 clk = ~clk;

  chain_led_driver #(.CH(W)) uut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi),
    .latch_en(latch_en), .blank(blank), .sdo(sdo_a), .sink_on(out_a));

  chain_led_driver #(.CH(W)) uut_b (
    .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdo_a),
    .latch_en(latch_en), .blank(blank), .sdo(sdo_b), .sink_on(out_b));

  int checks = 0;
  int fails  = 0;

  logic [2*W:0] expq[$];
  string        tagq[$];

  logic [L-1:0] m_chain = '0;
  logic [L-1:0] m_store = '0;

  // Driver: apply inputs on the falling edge, update the model after the
  // rising edge, queue the expected outputs.
  task automatic step(input logic r, input logic sh, input logic d,
                      input logic le, input logic bl, input string tag);
    logic [L-1:0] e;
    @(negedge clk);
    rst = r; shift_en = sh; sdi = d; latch_en = le; blank = bl;
    @(posedge clk);
    #1;
    if (r) begin
      m_chain = '0;
      m_store = '0;
    end else begin
      if (sh) m_chain = {m_chain[L-2:0], d};
      if (le) m_store = m_chain;
    end
    e = (r || bl) ? '0 : m_store;
    expq.push_back({m_chain[L-1] & ~r, e[L-1:W], e[W-1:0]});
    tagq.push_back(tag);
  endtask

  // Monitor: compare queued expectations on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (expq.size() > 0) begin
        logic [2*W:0] x;
        string t;
        x = expq.pop_front();
        t = tagq.pop_front();
        checks += 3;
        if (out_a !== x[W-1:0]) begin
          fails++;
          $display("FAIL %s: upstream sink_on act %h exp %h", t, out_a, x[W-1:0]);
        end
        if (out_b !== x[2*W-1:W]) begin
          fails++;
          $display("FAIL %s: downstream sink_on act %h exp %h", t, out_b, x[2*W-1:W]);
        end
        if (sdo_b !== x[2*W]) begin
          fails++;
          $display("FAIL %s: downstream sdo act %b exp %b", t, sdo_b, x[2*W]);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, act hung exp done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [L-1:0] PAT = 32'hA5C3_0F96;
  localparam logic [L-1:0] PAT2 = 32'h3C69_E187;

  initial begin
    // R10: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R10 reset");
    // R1 R2 R3 R5: load 32 bits with the storage closed; outputs stay off
    for (int i = L - 1; i >= 0; i--) step(0, 1, PAT[i], 0, 0, "R1 R2 R3 R5 load");
    // R2: no shift, no change
    step(0, 0, 1, 0, 0, "R2 idle");
    // R4 R8 R9 R3: capture pulse shows both vectors
    step(0, 0, 0, 1, 0, "R4 R8 R9 R3 capture");
    // R5: keep shifting with storage closed; outputs hold
    for (int i = 0; i < 8; i++) step(0, 1, i[0], 0, 0, "R5 hold");
    // R6 then R7: blanking hides, then restores without loss
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R6 blank");
    step(0, 1, 1, 0, 1, "R6 R7 blank with shift");
    step(0, 0, 0, 0, 0, "R7 unblank");
    step(0, 0, 0, 0, 0, "R7 shown");
    // R9: single marker bit ends at the top channel of the upstream block
    step(1, 0, 0, 0, 0, "R10 reset mid-run");
    step(0, 1, 1, 0, 0, "R9 marker");
    for (int i = 0; i < W - 1; i++) step(0, 1, 0, 0, 0, "R9 fill");
    step(0, 0, 0, 1, 0, "R9 marker at top channel");
    // R11: bypass with blanking during shifting
    for (int i = L - 1; i >= 0; i--) step(0, 1, PAT2[i], 1, 1, "R11 bypass blanked");
    step(0, 0, 0, 1, 0, "R11 bypass shown");
    // R4: transparent tracking while shifting visibly
    for (int i = 0; i < 6; i++) step(0, 1, ~i[0], 1, 0, "R4 follow");
    // R10: reset clears everything
    step(1, 0, 0, 1, 0, "R10 final reset");
    step(0, 0, 0, 0, 0, "R10 after reset");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule